// File: doc/BRIEF.md
# Host I/O Wake-Up Port Command Decoder

This block listens to a host I/O write bus for writes aimed at one configurable port address, the wake-up port. When a write strobe arrives and the address matches, the low data byte is taken as a one-byte command. The command either releases the local controller from reset and clears the pending interrupt, or pulses channel attention to the local I/O processor, or puts the controller back into reset. Every other byte value does nothing.

Controller reset is sticky. It comes up asserted after a system reset and after a reset command. It is released only when the host writes the release command. While reset is asserted, the block holds the local control register at zero and keeps the pending-interrupt flag clear. The host therefore brings the processor up by writing the release command and then the attention command. An attention command written while reset is still asserted is dropped.

A mode input chooses between 16-bit port addressing, where every address bit must match, and 8-bit port addressing, where only the low address byte is compared. All outputs are registered. Each one changes on the clock edge that samples the write.

Top module: `wake_port_decoder`

## Requirements
- R1: In 16-bit mode (wideAddrMode=1), a write strobe acts only when all 16 bits of hostAddr equal portAddr. A write to any other address, or a cycle with no strobe, changes no output.
- R2: In 8-bit mode (wideAddrMode=0), only hostAddr[7:0] is compared with portAddr[7:0], and hostAddr[15:8] has no effect on the match.
- R3: A matched write of 8'h00 drives ctrlResetOut low from the next clock edge on.
- R4: A matched write of 8'h00 clears intrPending on the next edge. The clear wins over an intrRaise in the same cycle, and intrRaise sets intrPending when neither reset nor a clear is active.
- R5: A matched write of 8'h01 while ctrlResetOut is low makes chanAttn high for exactly the one cycle after the write.
- R6: A matched write of 8'h01 while ctrlResetOut is high produces no chanAttn pulse and leaves ctrlResetOut high.
- R7: A matched write of 8'h02 drives ctrlResetOut high on the next edge. It stays high through any writes except 8'h00.
- R8: While ctrlResetOut is high, localRegQ is forced to zero on the next edge, local register writes are ignored, and intrPending is held at 0.
- R9: A matched write of any byte from 8'h03 to 8'hFF changes neither ctrlResetOut nor intrPending and produces no chanAttn.
- R10: After system reset (rstN low), ctrlResetOut is 1, and chanAttn, intrPending and localRegQ are 0.
- R11: While ctrlResetOut is low, localWe loads localWd into localRegQ on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| hostAddr | input | 16 | Host I/O write address |
| hostData | input | 8 | Host I/O write data (command byte) |
| hostWrStrobe | input | 1 | One-cycle host I/O write strobe |
| portAddr | input | 16 | Configured wake-up port address |
| wideAddrMode | input | 1 | 1: compare 16 address bits, 0: compare the low 8 only |
| intrRaise | input | 1 | Local request to set the pending interrupt |
| localWe | input | 1 | Local control register write enable |
| localWd | input | 8 | Local control register write data |
| ctrlResetOut | output | 1 | Sticky controller reset, active high |
| chanAttn | output | 1 | One-cycle channel-attention pulse |
| intrPending | output | 1 | Pending-interrupt flag |
| localRegQ | output | 8 | Local control register contents |

## Verification
The bench sweeps every high-byte and low-byte address value in both addressing modes and checks each one for a match through the reset command. A design that ignored the mode would miss writes in 8-bit mode or accept foreign ports in 16-bit mode. It also writes every undefined command byte with reset both asserted and released. A decoder that matched only some of the bits would then change the reset or interrupt state, or fire attention. Further cases target the ordering rules. These are attention before release (a design that let it through would start the processor while it is still held in reset), a clear in the same cycle as a raise (a wrong priority leaves the interrupt pending), and the one-cycle width of the attention pulse.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_RELEASE = 8'h00;
  localparam logic [CMD_W-1:0] CMD_ATTN    = 8'h01;
  localparam logic [CMD_W-1:0] CMD_HALT    = 8'h02;

  // strobes from the decode datapath to the control
  typedef struct packed {
    logic relStb;
    logic attnStb;
    logic haltStb;
  } cmdStrobes_t;

  // strobes from the control back to the datapath
  typedef struct packed {
    logic clearRegs;
  } dpCtrl_t;
endpackage

// File: rtl/wake_addr_match.sv
module wake_addr_match #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              wideAddrMode,
  output logic              addrHit
);
  localparam int LO_W = ADDR_W / 2;

  logic [ADDR_W-1:0] bitOk;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < LO_W) begin : g_lo
      assign bitOk[i] = (hostAddr[i] == portAddr[i]);
    end else begin : g_hi
      assign bitOk[i] = (hostAddr[i] == portAddr[i]) || !wideAddrMode;
    end
  end

  assign addrHit = &bitOk;
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [CMD_W-1:0]  hostData,
  input  logic              hostWrStrobe,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              wideAddrMode,
  input  logic              localWe,
  input  logic [REG_W-1:0]  localWd,
  input  dpCtrl_t           dpCtrl,
  output cmdStrobes_t       cmdStb,
  output logic [REG_W-1:0]  localRegQ
);
  logic addrHit;
  logic cmdValid;

  wake_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .hostAddr    (hostAddr),
    .portAddr    (portAddr),
    .wideAddrMode(wideAddrMode),
    .addrHit     (addrHit)
  );

  assign cmdValid = hostWrStrobe && addrHit;

  always_comb begin
    cmdStb = '0;
    if (cmdValid) begin
      unique case (hostData)
        CMD_RELEASE: cmdStb.relStb  = 1'b1;
        CMD_ATTN:    cmdStb.attnStb = 1'b1;
        CMD_HALT:    cmdStb.haltStb = 1'b1;
        default:     cmdStb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      localRegQ <= '0;
    end else if (dpCtrl.clearRegs) begin
      localRegQ <= '0;
    end else if (localWe) begin
      localRegQ <= localWd;
    end
  end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cmdStrobes_t cmdStb,
  input  logic        intrRaise,
  output dpCtrl_t     dpCtrl,
  output logic        ctrlResetOut,
  output logic        chanAttn,
  output logic        intrPending
);
  logic resetQ;
  logic attnQ;
  logic pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetQ <= 1'b1;
      attnQ  <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      attnQ <= cmdStb.attnStb && !resetQ;
      if (cmdStb.haltStb) begin
        resetQ <= 1'b1;
      end else if (cmdStb.relStb) begin
        resetQ <= 1'b0;
      end
      if (resetQ || cmdStb.relStb || cmdStb.haltStb) begin
        pendQ <= 1'b0;
      end else if (intrRaise) begin
        pendQ <= 1'b1;
      end
    end
  end

  assign dpCtrl.clearRegs = resetQ;
  assign ctrlResetOut     = resetQ;
  assign chanAttn         = attnQ;
  assign intrPending      = pendQ;
endmodule

// File: rtl/wake_port_decoder.sv
module wake_port_decoder
  import wake_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [CMD_W-1:0]  hostData,
  input  logic              hostWrStrobe,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              wideAddrMode,
  input  logic              intrRaise,
  input  logic              localWe,
  input  logic [REG_W-1:0]  localWd,
  output logic              ctrlResetOut,
  output logic              chanAttn,
  output logic              intrPending,
  output logic [REG_W-1:0]  localRegQ
);
  cmdStrobes_t cmdStb;
  dpCtrl_t     dpCtrl;

  wake_datapath #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .hostAddr    (hostAddr),
    .hostData    (hostData),
    .hostWrStrobe(hostWrStrobe),
    .portAddr    (portAddr),
    .wideAddrMode(wideAddrMode),
    .localWe     (localWe),
    .localWd     (localWd),
    .dpCtrl      (dpCtrl),
    .cmdStb      (cmdStb),
    .localRegQ   (localRegQ)
  );

  wake_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdStb      (cmdStb),
    .intrRaise   (intrRaise),
    .dpCtrl      (dpCtrl),
    .ctrlResetOut(ctrlResetOut),
    .chanAttn    (chanAttn),
    .intrPending (intrPending)
  );
endmodule

// File: rtl/wake_port_checker.sv
module wake_port_checker #(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [7:0]        hostData,
  input logic              hostWrStrobe,
  input logic [ADDR_W-1:0] portAddr,
  input logic              wideAddrMode,
  input logic              intrRaise,
  input logic              ctrlResetOut,
  input logic              chanAttn,
  input logic              intrPending,
  input logic [REG_W-1:0]  localRegQ
);
  localparam int LO_W = ADDR_W / 2;

  logic hitNow;
  logic wrRel;
  logic wrAttn;
  logic wrHalt;
  logic wrOther;

  assign hitNow  = hostWrStrobe && (wideAddrMode ? (hostAddr == portAddr)
                                                 : (hostAddr[LO_W-1:0] == portAddr[LO_W-1:0]));
  assign wrRel   = hitNow && (hostData == 8'h00);
  assign wrAttn  = hitNow && (hostData == 8'h01);
  assign wrHalt  = hitNow && (hostData == 8'h02);
  assign wrOther = hitNow && (hostData > 8'h02);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrRel |=> !ctrlResetOut);

  assert_clear_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrRel |=> !intrPending);

  assert_attn_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    chanAttn |-> $past(wrAttn && !ctrlResetOut));

  assert_attn_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrAttn && ctrlResetOut) |=> (!chanAttn && ctrlResetOut));

  assert_halt_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrHalt |=> ctrlResetOut);

  assert_reset_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlResetOut && !wrRel) |=> ctrlResetOut);

  assert_reg_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlResetOut |=> (localRegQ == '0));

  assert_pending_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlResetOut |-> !intrPending);

  assert_other_cmd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrOther && !ctrlResetOut) |=> (!ctrlResetOut && !chanAttn));

  assert_no_hit_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!hitNow && !ctrlResetOut && !intrRaise) |=>
      (!ctrlResetOut && !chanAttn && $stable(intrPending)));
endmodule

bind wake_port_decoder wake_port_checker #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .hostAddr    (hostAddr),
  .hostData    (hostData),
  .hostWrStrobe(hostWrStrobe),
  .portAddr    (portAddr),
  .wideAddrMode(wideAddrMode),
  .intrRaise   (intrRaise),
  .ctrlResetOut(ctrlResetOut),
  .chanAttn    (chanAttn),
  .intrPending (intrPending),
  .localRegQ   (localRegQ)
);

// File: tb/wake_port_decoder_bench.sv
`timescale 1ns/1ps
module wake_port_decoder_bench;
  localparam logic [15:0] PORT = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostData = '0;
  logic        hostWrStrobe = 1'b0;
  logic [15:0] portAddr = PORT;
  logic        wideAddrMode = 1'b1;
  logic        intrRaise = 1'b0;
  logic        localWe = 1'b0;
  logic [7:0]  localWd = '0;
  logic        ctrlResetOut;
  logic        chanAttn;
  logic        intrPending;
  logic [7:0]  localRegQ;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_port_decoder u_wake_port_decoder (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostData(hostData),
    .hostWrStrobe(hostWrStrobe), .portAddr(portAddr), .wideAddrMode(wideAddrMode),
    .intrRaise(intrRaise), .localWe(localWe), .localWd(localWd),
    .ctrlResetOut(ctrlResetOut), .chanAttn(chanAttn), .intrPending(intrPending),
    .localRegQ(localRegQ)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with results visible
  task automatic hostWrite(input logic [15:0] a, input logic [7:0] d);
    hostAddr = a;
    hostData = d;
    hostWrStrobe = 1'b1;
    @(negedge clk);
    hostWrStrobe = 1'b0;
  endtask

  task automatic raiseIntr();
    intrRaise = 1'b1;
    @(negedge clk);
    intrRaise = 1'b0;
  endtask

  task automatic addrSweep(input logic wide);
    wideAddrMode = wide;
    for (int h = 0; h < 256; h++) begin
      logic expHit;
      expHit = !wide || (h[7:0] == PORT[15:8]);
      hostWrite({h[7:0], PORT[7:0]}, 8'h02);
      chk(wide ? "R1 high byte" : "R2 high byte ignored", ctrlResetOut, expHit);
      if (ctrlResetOut) hostWrite(PORT, 8'h00);
    end
    for (int l = 0; l < 256; l++) begin
      logic expHit;
      expHit = (l[7:0] == PORT[7:0]);
      hostWrite({PORT[15:8], l[7:0]}, 8'h02);
      chk(wide ? "R1 low byte" : "R2 low byte", ctrlResetOut, expHit);
      if (ctrlResetOut) hostWrite(PORT, 8'h00);
    end
    wideAddrMode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset", ctrlResetOut, 1);
    chk("R10 attn", chanAttn, 0);
    chk("R10 pending", intrPending, 0);
    chk("R10 reg", localRegQ, 0);

    // R8 local write ignored during reset, pending held
    localWe = 1'b1; localWd = 8'hA5;
    intrRaise = 1'b1;
    @(negedge clk);
    localWe = 1'b0; intrRaise = 1'b0;
    chk("R8 reg held", localRegQ, 0);
    chk("R8 pending held", intrPending, 0);

    // R6 attention before release is dropped
    hostWrite(PORT, 8'h01);
    chk("R6 no attn", chanAttn, 0);
    chk("R6 reset stays", ctrlResetOut, 1);

    // R9 undefined commands while in reset
    for (int v = 3; v < 256; v++) begin
      hostWrite(PORT, v[7:0]);
      chk("R9 reset kept", ctrlResetOut, 1);
      chk("R9 no attn", chanAttn, 0);
    end

    // R3 release
    hostWrite(PORT, 8'h00);
    chk("R3 released", ctrlResetOut, 0);

    // R5 attention pulse, exactly one cycle
    hostWrite(PORT, 8'h01);
    chk("R5 attn high", chanAttn, 1);
    @(negedge clk);
    chk("R5 attn one cycle", chanAttn, 0);

    // R4 raise then clear
    raiseIntr();
    chk("R4 raised", intrPending, 1);
    hostWrite(PORT, 8'h00);
    chk("R4 cleared", intrPending, 0);
    // R4 clear beats simultaneous raise
    raiseIntr();
    intrRaise = 1'b1;
    hostWrite(PORT, 8'h00);
    intrRaise = 1'b0;
    chk("R4 clear wins", intrPending, 0);

    // R9 undefined commands while released, with pending set
    raiseIntr();
    for (int v = 3; v < 256; v++) begin
      hostWrite(PORT, v[7:0]);
      chk("R9 reset low", ctrlResetOut, 0);
      chk("R9 no attn", chanAttn, 0);
      chk("R9 pending kept", intrPending, 1);
    end

    // R1 non-matching and unstrobed cycles
    hostWrite(PORT ^ 16'h0100, 8'h02);
    chk("R1 wrong high byte", ctrlResetOut, 0);
    hostAddr = PORT; hostData = 8'h02;
    @(negedge clk);
    chk("R1 no strobe", ctrlResetOut, 0);
    chk("R1 pending kept", intrPending, 1);

    // R11 local register load
    localWe = 1'b1; localWd = 8'h3C;
    @(negedge clk);
    localWe = 1'b0;
    chk("R11 reg loaded", localRegQ, 8'h3C);

    // R7 halt, R8 clears register and pending
    hostWrite(PORT, 8'h02);
    chk("R7 reset set", ctrlResetOut, 1);
    chk("R8 pending cleared", intrPending, 0);
    @(negedge clk);
    chk("R8 reg cleared", localRegQ, 0);
    hostWrite(PORT, 8'h01);
    chk("R7 sticky over attn", ctrlResetOut, 1);
    hostWrite(PORT, 8'h02);
    chk("R7 sticky over halt", ctrlResetOut, 1);
    hostWrite(PORT, 8'h00);
    chk("R3 release again", ctrlResetOut, 0);

    // R1 and R2 address sweeps
    addrSweep(1'b1);
    addrSweep(1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule